// File: doc/BRIEF.md
# Synchronized Clock-Stop and Power-Down Controller

This block takes one fast master clock and turns it into five divided clock lines: two CPU-rate banks (A and B), a PCI bank, a reference bank and an auxiliary bank. Each line drives one bank. Fanning a line out to the bank's pins is done outside the block. Every divided line is a register output, so it has no glitches. Each bank has its own free-running phase counter. A bank changes between running and stopped only at the last low count of its own period. A stopped bank therefore always ends on a complete high pulse and restarts with one.

Three active-low asynchronous controls steer the block. One stops the PCI bank, one stops CPU bank B, and one requests power-down. Each control passes through a two-stage synchronizer before any logic uses it. On power-down the block parks every bank low and raises a parked flag. It then drops the PLL enable, and one cycle later the oscillator enable. On wake-up it raises the oscillator enable and waits a settling count. It then raises the PLL enable, waits a second settling count, and only after that lets the banks run again. The block is used in front of an analog clock source to give glitch-free clock gating and an ordered low-power sequence.

Top module: `clk_stop_ctrl`

## Requirements
- R1: The power-down, PCI-stop and CPU-B-stop inputs are active low (0 = request). Each passes through two master-clock flops before it acts. A stop or power-down request held low stops its banks, and releasing it lets them restart.
- R2: A stopped bank output stays at logic 0 with no rising edge for as long as it is stopped. This covers stops by its own control and stops during power-down.
- R3: Bank dividers default to 2 (CPU A), 2 (CPU B), 8 (PCI), 6 (reference) and 4 (auxiliary). Every high pulse lasts exactly half the divider in master cycles, and it starts when the bank's phase counter restarts.
- R4: Every low interval of a bank lasts half its divider plus a whole number of its periods. A stop never shortens a high phase, and a restart never yields a runt pulse.
- R5: From the third master clock edge after a stop input falls, at most one further rising edge appears on the affected bank.
- R6: The PCI stop affects only the PCI bank, and the CPU-B stop affects only CPU bank B. All other banks keep toggling, including while the PCI bank stays stopped across a power-down and wake-up.
- R7: On power-down the events come in this order: the parked flag rises with every output low, then the PLL enable falls, then the oscillator enable falls exactly one cycle later.
- R8: On power-down release the oscillator enable rises first. The PLL enable rises exactly OSC_SETTLE (default 40) cycles later. Banks are released PLL_SETTLE (default 60) cycles after that, so CPU bank A first rises between OSC_SETTLE+PLL_SETTLE+4 and OSC_SETTLE+PLL_SETTLE+3+CPU divider cycles after the release.
- R9: During reset all clock outputs are 0, both enables are 1 and the parked flag is 1. After reset every bank starts toggling and the parked flag falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock at the CPU rate multiple |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwrDown_n | input | 1 | Asynchronous power-down request, low active |
| pciStop_n | input | 1 | Asynchronous PCI bank stop, low active |
| cpuBStop_n | input | 1 | Asynchronous CPU bank B stop, low active |
| cpuClkA | output | 1 | CPU bank A clock line |
| cpuClkB | output | 1 | CPU bank B clock line |
| pciClk | output | 1 | PCI bank clock line |
| refClk | output | 1 | Reference bank clock line |
| auxClk | output | 1 | Auxiliary bank clock line |
| pllEn | output | 1 | PLL enable |
| oscEn | output | 1 | Oscillator enable |
| allParked | output | 1 | All banks stopped and low |

## Verification
The hardest case to reach is a bank whose stop request lands in the middle of a high phase, or whose restart lands in the middle of a low phase. Only then would a careless gate cut a pulse short. Because the banks have different periods, the stimulus changes the controls on master-clock phases that are unrelated to every bank's period. A monitor measures every high and low run of every bank and compares it with the full-pulse rule. The power-down path is run both on its own and while the PCI bank is already stopped, so the restart after wake-up must still honour the earlier stop.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

  localparam int NUM_BANKS  = 5;
  localparam int BANK_CPU_A = 0;
  localparam int BANK_CPU_B = 1;
  localparam int BANK_PCI   = 2;
  localparam int BANK_REF   = 3;
  localparam int BANK_AUX   = 4;

  // Strobes from the control side to the divider datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0] bankReq;
  } stopStrobes_t;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_PARK     = 3'd1,
    ST_PLL_OFF  = 3'd2,
    ST_SLEEP    = 3'd3,
    ST_OSC_WAKE = 3'd4,
    ST_PLL_WAKE = 3'd5
  } pwrState_t;

endpackage

// File: rtl/clk_stop_sync.sv
module clk_stop_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] metaStage;

  // Two-flop synchronizer; resets to the inactive (high) level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      metaStage <= '1;
      syncOut   <= '1;
    end else begin
      metaStage <= asyncIn;
      syncOut   <= metaStage;
    end
  end

endmodule

// File: rtl/clk_stop_divbank.sv
module clk_stop_divbank #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic clkOut,
  output logic runNext
);

  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] phaseCnt;
  logic [CW-1:0] phaseNext;
  logic          running;
  logic          atEnd;

  assign atEnd     = (phaseCnt == CW'(DIV - 1));
  assign phaseNext = atEnd ? '0 : phaseCnt + 1'b1;
  // The enable is only re-sampled at the last low count of the period
  assign runNext   = atEnd ? req : running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt <= '0;
      running  <= 1'b0;
      clkOut   <= 1'b0;
    end else begin
      phaseCnt <= phaseNext;
      running  <= runNext;
      clkOut   <= runNext && (phaseNext < CW'(HALF));
    end
  end

  // R3: a rising edge only comes at the start of the bank's period
  p_rise_at_phase_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkOut) |-> (phaseCnt == '0));

  // R3: a falling edge only comes after a full half period
  p_fall_at_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clkOut) |-> (phaseCnt == CW'(HALF)));

  // R4: run/stop state changes only across the period boundary
  p_switch_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(running) |-> $past(atEnd));

endmodule

// File: rtl/clk_stop_datapath.sv
module clk_stop_datapath
  import clk_stop_pkg::*;
#(
  parameter int CPU_DIV = 2,
  parameter int PCI_DIV = 8,
  parameter int REF_DIV = 6,
  parameter int AUX_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  stopStrobes_t         strobes,
  output logic [NUM_BANKS-1:0] bankClk,
  output logic                 allParked
);

  logic [NUM_BANKS-1:0] runNextVec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BANK_DIV = (b == BANK_PCI) ? PCI_DIV :
                              (b == BANK_REF) ? REF_DIV :
                              (b == BANK_AUX) ? AUX_DIV : CPU_DIV;
    clk_stop_divbank #(.DIV(BANK_DIV)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (strobes.bankReq[b]),
      .clkOut  (bankClk[b]),
      .runNext (runNextVec[b])
    );
  end

  // Parked flag follows the same edge that updates every bank's state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) allParked <= 1'b1;
    else        allParked <= ~|runNextVec;
  end

  // R7: the parked flag never coexists with a high clock line
  p_parked_outputs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    allParked |-> (bankClk == '0));

endmodule

// File: rtl/clk_stop_ctrl_fsm.sv
module clk_stop_ctrl_fsm
  import clk_stop_pkg::*;
#(
  parameter int OSC_SETTLE = 40,
  parameter int PLL_SETTLE = 60
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwrDown_n,
  input  logic         pciStop_n,
  input  logic         cpuBStop_n,
  input  logic         allParked,
  output stopStrobes_t strobes,
  output logic         pllEn,
  output logic         oscEn
);

  localparam int SMAX = (OSC_SETTLE > PLL_SETTLE) ? OSC_SETTLE : PLL_SETTLE;
  localparam int SW   = $clog2(SMAX + 1);

  logic [2:0]    syncLvl;
  logic          pdGo;
  logic          pciGo;
  logic          cpuBGo;
  pwrState_t     state;
  pwrState_t     nextState;
  logic [SW-1:0] settleCnt;
  logic [SW-1:0] settleNext;
  logic          holdBanks;

  clk_stop_sync #(.WIDTH(3)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({cpuBStop_n, pciStop_n, pwrDown_n}),
    .syncOut (syncLvl)
  );

  assign pdGo   = syncLvl[0];
  assign pciGo  = syncLvl[1];
  assign cpuBGo = syncLvl[2];

  always_comb begin
    nextState  = state;
    settleNext = settleCnt;
    unique case (state)
      ST_RUN:      if (!pdGo) nextState = ST_PARK;
      ST_PARK:     if (allParked) nextState = ST_PLL_OFF;
      ST_PLL_OFF:  nextState = ST_SLEEP;
      ST_SLEEP: begin
        if (pdGo) begin
          nextState  = ST_OSC_WAKE;
          settleNext = SW'(OSC_SETTLE - 1);
        end
      end
      ST_OSC_WAKE: begin
        if (!pdGo) nextState = ST_SLEEP;
        else if (settleCnt == '0) begin
          nextState  = ST_PLL_WAKE;
          settleNext = SW'(PLL_SETTLE - 1);
        end else settleNext = settleCnt - 1'b1;
      end
      ST_PLL_WAKE: begin
        if (!pdGo) nextState = ST_PLL_OFF;
        else if (settleCnt == '0) nextState = ST_RUN;
        else settleNext = settleCnt - 1'b1;
      end
      default:     nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      settleCnt <= '0;
      pllEn     <= 1'b1;
      oscEn     <= 1'b1;
    end else begin
      state     <= nextState;
      settleCnt <= settleNext;
      pllEn     <= (nextState == ST_RUN) || (nextState == ST_PARK) ||
                   (nextState == ST_PLL_WAKE);
      oscEn     <= (nextState != ST_SLEEP);
    end
  end

  assign holdBanks = (state != ST_RUN);

  always_comb begin
    strobes.bankReq             = {NUM_BANKS{!holdBanks}};
    strobes.bankReq[BANK_PCI]   = !holdBanks && pciGo;
    strobes.bankReq[BANK_CPU_B] = !holdBanks && cpuBGo;
  end

  // R7: the PLL is switched off only once every bank is parked
  p_pll_off_after_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pllEn) |-> allParked);

  // R7: the oscillator goes off only after the PLL has been off for a cycle
  p_osc_off_after_pll_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oscEn) |-> (!pllEn && $past(!pllEn)));

  // R8: the PLL never runs without the oscillator
  p_pll_needs_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pllEn |-> oscEn);

  // R8: banks are released only while the PLL was already enabled
  p_release_after_pll_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) != ST_RUN) |-> $past(pllEn));

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int CPU_DIV    = 2,
  parameter int PCI_DIV    = 8,
  parameter int REF_DIV    = 6,
  parameter int AUX_DIV    = 4,
  parameter int OSC_SETTLE = 40,
  parameter int PLL_SETTLE = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrDown_n,
  input  logic pciStop_n,
  input  logic cpuBStop_n,
  output logic cpuClkA,
  output logic cpuClkB,
  output logic pciClk,
  output logic refClk,
  output logic auxClk,
  output logic pllEn,
  output logic oscEn,
  output logic allParked
);

  stopStrobes_t         strobes;
  logic [NUM_BANKS-1:0] bankClk;

  clk_stop_ctrl_fsm #(
    .OSC_SETTLE (OSC_SETTLE),
    .PLL_SETTLE (PLL_SETTLE)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwrDown_n  (pwrDown_n),
    .pciStop_n  (pciStop_n),
    .cpuBStop_n (cpuBStop_n),
    .allParked  (allParked),
    .strobes    (strobes),
    .pllEn      (pllEn),
    .oscEn      (oscEn)
  );

  clk_stop_datapath #(
    .CPU_DIV (CPU_DIV),
    .PCI_DIV (PCI_DIV),
    .REF_DIV (REF_DIV),
    .AUX_DIV (AUX_DIV)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .bankClk   (bankClk),
    .allParked (allParked)
  );

  assign cpuClkA = bankClk[BANK_CPU_A];
  assign cpuClkB = bankClk[BANK_CPU_B];
  assign pciClk  = bankClk[BANK_PCI];
  assign refClk  = bankClk[BANK_REF];
  assign auxClk  = bankClk[BANK_AUX];

endmodule

// File: tb/clk_stop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_stop_ctrl_tb_top;

  localparam int CPU_DIV    = 2;
  localparam int PCI_DIV    = 8;
  localparam int REF_DIV    = 6;
  localparam int AUX_DIV    = 4;
  localparam int OSC_SETTLE = 40;
  localparam int PLL_SETTLE = 60;
  localparam int NB         = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrDown_n = 1'b1;
  logic pciStop_n = 1'b1;
  logic cpuBStop_n = 1'b1;
  logic cpuClkA, cpuClkB, pciClk, refClk, auxClk, pllEn, oscEn, allParked;
  logic [NB-1:0] outs;

  clk_stop_ctrl #(
    .CPU_DIV(CPU_DIV), .PCI_DIV(PCI_DIV), .REF_DIV(REF_DIV), .AUX_DIV(AUX_DIV),
    .OSC_SETTLE(OSC_SETTLE), .PLL_SETTLE(PLL_SETTLE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pwrDown_n(pwrDown_n), .pciStop_n(pciStop_n),
    .cpuBStop_n(cpuBStop_n), .cpuClkA(cpuClkA), .cpuClkB(cpuClkB),
    .pciClk(pciClk), .refClk(refClk), .auxClk(auxClk), .pllEn(pllEn),
    .oscEn(oscEn), .allParked(allParked)
  );

  assign outs = {auxClk, refClk, pciClk, cpuClkB, cpuClkA};

  always #2.5 clk = ~clk;

  int cycle = 0;
  always @(posedge clk) cycle <= cycle + 1;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- bank pulse monitor (R3, R4) ----------------
  int divOf [NB] = '{CPU_DIV, CPU_DIV, PCI_DIV, REF_DIV, AUX_DIV};
  int runLen [NB];
  int riseCnt [NB];
  bit prevV [NB];
  bit started [NB];
  bit monOn = 1'b0;

  always @(negedge clk) begin
    if (monOn) begin
      for (int b = 0; b < NB; b++) begin
        if (outs[b] != prevV[b]) begin
          if (started[b]) begin
            if (prevV[b])
              check(runLen[b] == divOf[b] / 2, "R3", $sformatf("bank %0d high width", b),
                    runLen[b], divOf[b] / 2);
            else
              check(runLen[b] >= divOf[b] / 2 &&
                    ((runLen[b] - divOf[b] / 2) % divOf[b]) == 0, "R4",
                    $sformatf("bank %0d low width", b), runLen[b], divOf[b] / 2);
          end
          if (outs[b]) begin
            started[b] = 1'b1;
            riseCnt[b]++;
          end
          runLen[b] = 1;
        end else begin
          runLen[b]++;
        end
        prevV[b] = outs[b];
      end
    end
  end

  // ---------------- power sequence scoreboard (R7, R8) ----------------
  // codes: 1 parked rise, 2 PLL off, 3 osc off, 4 osc on, 5 PLL on
  int expQ [$];
  bit pParked = 1'b1, pPll = 1'b1, pOsc = 1'b1;
  int pllFallC, oscFallC, oscRiseC, pllRiseC;

  task automatic pushExp(int code);
    expQ.push_back(code);
  endtask

  task automatic gotEvent(int code);
    string req;
    req = (code >= 4) ? "R8" : "R7";
    if (expQ.size() == 0) check(1'b0, req, "unexpected power event", code, 0);
    else begin
      int e;
      e = expQ.pop_front();
      check(e == code, req, "power event order", code, e);
    end
  endtask

  always @(negedge clk) begin
    if (monOn) begin
      if (allParked && !pParked) begin
        gotEvent(1);
        check(outs == '0, "R7", "outputs when parked flag rises", int'(outs), 0);
      end
      if (!pllEn && pPll) begin
        gotEvent(2);
        pllFallC = cycle;
        check(outs == '0, "R7", "outputs when PLL disabled", int'(outs), 0);
      end
      if (!oscEn && pOsc) begin gotEvent(3); oscFallC = cycle; end
      if (oscEn && !pOsc) begin gotEvent(4); oscRiseC = cycle; end
      if (pllEn && !pPll) begin gotEvent(5); pllRiseC = cycle; end
      pParked = allParked;
      pPll    = pllEn;
      pOsc    = oscEn;
    end
  end

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic snap(output int s [NB]);
    for (int b = 0; b < NB; b++) s[b] = riseCnt[b];
  endtask

  task automatic stopBank(int b);
    int s0 [NB];
    int s1 [NB];
    if (b == 2) pciStop_n = 1'b0; else cpuBStop_n = 1'b0;
    waitCycles(3);
    snap(s0);
    waitCycles(2 * divOf[b]);
    check(riseCnt[b] - s0[b] <= 1, "R5", $sformatf("bank %0d rises after stop", b),
          riseCnt[b] - s0[b], 1);
    snap(s1);
    waitCycles(60);
    check(riseCnt[b] == s1[b], "R2", $sformatf("bank %0d rises while stopped", b),
          riseCnt[b] - s1[b], 0);
    check(outs[b] == 1'b0, "R2", $sformatf("bank %0d level while stopped", b),
          int'(outs[b]), 0);
    for (int o = 0; o < NB; o++)
      if (o != b)
        check(riseCnt[o] > s1[o], "R6", $sformatf("bank %0d keeps running", o),
              riseCnt[o] - s1[o], 1);
    if (b == 2) pciStop_n = 1'b1; else cpuBStop_n = 1'b1;
    waitCycles(40);
    check(riseCnt[b] > s1[b], "R1", $sformatf("bank %0d restarts on release", b),
          riseCnt[b] - s1[b], 1);
  endtask

  initial begin
    int s [NB];
    int t0;
    int lat;
    waitCycles(3);
    // R9 reset state
    check(outs == '0, "R9", "outputs in reset", int'(outs), 0);
    check(pllEn == 1'b1, "R9", "PLL enable in reset", int'(pllEn), 1);
    check(oscEn == 1'b1, "R9", "oscillator enable in reset", int'(oscEn), 1);
    check(allParked == 1'b1, "R9", "parked flag in reset", int'(allParked), 1);
    rst_n = 1'b1;
    monOn = 1'b1;
    waitCycles(40);
    for (int b = 0; b < NB; b++)
      check(riseCnt[b] > 0, "R9", $sformatf("bank %0d toggles after reset", b), riseCnt[b], 1);
    check(allParked == 1'b0, "R9", "parked flag after reset", int'(allParked), 0);

    // single-bank stops, at phases unrelated to the periods
    waitCycles(3);
    stopBank(2);
    waitCycles(5);
    stopBank(1);

    // both stops together, staggered release
    waitCycles(7);
    pciStop_n  = 1'b0;
    cpuBStop_n = 1'b0;
    waitCycles(30);
    snap(s);
    waitCycles(40);
    check(riseCnt[2] == s[2] && riseCnt[1] == s[1], "R1", "both stopped banks quiet",
          riseCnt[2] - s[2] + riseCnt[1] - s[1], 0);
    check(riseCnt[0] > s[0], "R6", "CPU A runs during both stops", riseCnt[0] - s[0], 1);
    cpuBStop_n = 1'b1;
    waitCycles(21);
    check(riseCnt[1] > s[1], "R6", "CPU B restarts alone", riseCnt[1] - s[1], 1);
    check(riseCnt[2] == s[2], "R6", "PCI stays stopped", riseCnt[2] - s[2], 0);
    pciStop_n = 1'b1;
    waitCycles(30);

    // power-down and wake-up
    pushExp(1); pushExp(2); pushExp(3);
    pwrDown_n = 1'b0;
    waitCycles(60);
    check(expQ.size() == 0, "R7", "shutdown events seen", expQ.size(), 0);
    check(oscFallC - pllFallC == 1, "R7", "PLL to oscillator off spacing",
          oscFallC - pllFallC, 1);
    snap(s);
    waitCycles(50);
    for (int b = 0; b < NB; b++)
      check(riseCnt[b] == s[b], "R2", $sformatf("bank %0d quiet in sleep", b),
            riseCnt[b] - s[b], 0);
    pushExp(4); pushExp(5);
    t0 = cycle;
    pwrDown_n = 1'b1;
    lat = -1;
    for (int i = 0; i < 1000 && lat < 0; i++) begin
      @(negedge clk);
      if (cpuClkA) lat = cycle - t0;
    end
    check(lat >= OSC_SETTLE + PLL_SETTLE + 4 && lat <= OSC_SETTLE + PLL_SETTLE + 3 + CPU_DIV,
          "R8", "wake latency to first CPU A edge", lat, OSC_SETTLE + PLL_SETTLE + 3 + CPU_DIV);
    check(pllRiseC - oscRiseC == OSC_SETTLE, "R8", "oscillator to PLL on spacing",
          pllRiseC - oscRiseC, OSC_SETTLE);
    check(expQ.size() == 0, "R8", "wake events seen", expQ.size(), 0);
    waitCycles(20);

    // power-down while PCI is already stopped
    pciStop_n = 1'b0;
    waitCycles(11);
    pushExp(1); pushExp(2); pushExp(3);
    pwrDown_n = 1'b0;
    waitCycles(60);
    pushExp(4); pushExp(5);
    pwrDown_n = 1'b1;
    waitCycles(OSC_SETTLE + PLL_SETTLE + 30);
    snap(s);
    waitCycles(40);
    check(riseCnt[2] == s[2], "R6", "PCI stays stopped across wake", riseCnt[2] - s[2], 0);
    check(riseCnt[0] > s[0], "R8", "CPU A runs after wake", riseCnt[0] - s[0], 1);
    pciStop_n = 1'b1;
    waitCycles(40);
    check(riseCnt[2] > s[2], "R1", "PCI restarts after release", riseCnt[2] - s[2], 1);
    check(expQ.size() == 0, "R7", "all power events consumed", expQ.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1-watchdog run did not complete: actual=%0d expected=%0d", cycle, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule